// File: doc/BRIEF.md
# Erasable Byte Store Behavioural Model

This block is a clocked, synthesizable model of a byte-wide memory whose cells can only be cleared by writing and set again only by a bulk erase. It has a 16-bit address, separate 8-bit data-in and data-out buses with a drive-enable flag in place of a three-state pin, an active-low chip select and an active-low output enable. Two one-bit inputs stand in for high-voltage conditions. `vpp_hi` marks the programming supply as applied. `id_hi` marks the identifier voltage on address line 9.

From these pins the model decodes seven modes: read, output disabled, standby, program, program inhibit, program verify and identifier readout. Program verify is an ordinary read taken after programming. A write merges the input byte into the cell with a bitwise AND, so a write can turn bits from one to zero but never back. The `erase` input returns every cell to FFh. The `DEPTH` parameter shrinks the array for simulation, and the address then wraps on its low bits. The data port is a plain memory bus. It has no valid/ready handshake and never applies back-pressure: a read result is available combinationally in the same cycle.

Top module: `erasable_byte_store`

## Requirements
- R1: After reset is released, every location reads FFh.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hi`=0, `dout_en`=1 and `dout` shows, in the same cycle, the byte stored at address bits [log2(DEPTH)-1:0]. Higher address bits are ignored, so an address and that address plus DEPTH read the same cell.
- R3: While `ce_n`=1, `dout_en`=0 whatever the other inputs are, and `dout` is 00h whenever `dout_en`=0.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, `dout_en`=0.
- R5: While `vpp_hi`=1, `dout_en`=0 in every case.
- R6: A clock edge at which `vpp_hi`=1 and `ce_n` is sampled 0 after having been sampled 1 on the previous edge stores (old AND `din`) at the addressed cell. No other cell changes, and no bit rises from 0 to 1.
- R7: No write happens while `ce_n` stays high with `vpp_hi`=1. While `ce_n` stays low, only its first low edge writes, so `din` changes after that edge have no effect.
- R8: A clock edge with `erase`=1 sets every cell to FFh. If a program edge falls in the same cycle, the erase wins.
- R9: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hi`=1, the output is an identifier byte. Address bit 0 = 0 gives 97h and bit 0 = 1 gives 85h. Bit 7 of each byte makes its parity odd. Address bit 9 is ignored. Any other nonzero address bit gives 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also fills the array with FFh |
| ce_n | input | 1 | Active-low chip select; a falling edge with `vpp_hi` writes |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply applied |
| id_hi | input | 1 | Identifier voltage present on address line 9 |
| erase | input | 1 | Bulk erase of all cells to FFh |
| addr | input | 16 | Byte address |
| din | input | 8 | Data to merge into the cell on a write |
| dout | output | 8 | Read or identifier data; 00h when not driven |
| dout_en | output | 1 | High when the model drives the data bus |

## Verification
Bulk erase and a program edge can land on the same clock edge. The bench provokes this by lowering `ce_n` with `vpp_hi` set in the very cycle that `erase` is high. It then reads back the targeted cell and several others and expects FFh everywhere, which shows the erase took precedence. A second overlap is the identifier flag held during a program pulse. There the bench expects the output to stay undriven, and it expects the cell to be written as if the flag were absent.

// File: rtl/erom_pkg.sv
package erom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_INHIBIT,
    M_DISABLE,
    M_PROGRAM,
    M_READ,
    M_IDENT
  } erom_mode_e;

  // Byte whose top bit gives odd parity over all eight bits
  function automatic logic [7:0] odd_par_byte(input logic [6:0] low7);
    return {~(^low7), low7};
  endfunction

endpackage

// File: rtl/erom_mode_dec.sv
module erom_mode_dec
  import erom_pkg::*;
(
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       vpp_hi,
  input  logic       id_hi,
  output erom_mode_e mode,
  output logic       drive,
  output logic       ident_sel
);

  always_comb begin
    if (ce_n)        mode = vpp_hi ? M_INHIBIT : M_STANDBY;
    else if (vpp_hi) mode = M_PROGRAM;
    else if (oe_n)   mode = M_DISABLE;
    else if (id_hi)  mode = M_IDENT;
    else             mode = M_READ;
  end

  assign drive     = (mode == M_READ) || (mode == M_IDENT);
  assign ident_sel = (mode == M_IDENT);

endmodule

// File: rtl/erom_pulse_det.sv
module erom_pulse_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic vpp_hi,
  output logic wr_fire
);

  logic ce_n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ce_n_q <= 1'b1;
    else        ce_n_q <= ce_n;
  end

  assign wr_fire = vpp_hi && !ce_n && ce_n_q;

  // Holding ce_n low never yields a second write
  p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);

endmodule

// File: rtl/erom_cell_array.sv
module erom_cell_array #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] ridx,
  output logic [7:0]    rdata
);

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (wr_en) begin
      cells[widx] <= cells[widx] & wdata;
    end
  end

  assign rdata = cells[ridx];

  // Checker state: previous write target and its old contents
  logic [7:0]    old_q;
  logic [AW-1:0] widx_q;
  logic          wr_q;
  logic          er_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q  <= 8'hFF;
      widx_q <= '0;
      wr_q   <= 1'b0;
      er_q   <= 1'b0;
    end else begin
      old_q  <= cells[widx];
      widx_q <= widx;
      wr_q   <= wr_en;
      er_q   <= erase;
    end
  end

  // A write never raises a cleared bit
  p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !er_q) |-> ((cells[widx_q] & ~old_q) == 8'h00));

  // Right after an erase edge any cell reads all ones
  p_erase_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    er_q |-> (rdata == 8'hFF));

endmodule

// File: rtl/erom_ident_rom.sv
module erom_ident_rom
  import erom_pkg::*;
#(
  parameter logic [6:0] MFG_LOW7 = 7'h17,
  parameter logic [6:0] DEV_LOW7 = 7'h05
) (
  input  logic [15:0] addr,
  output logic [7:0]  ident
);

  localparam logic [15:0] OTHER_BITS = 16'hFDFE;

  logic stray;
  assign stray = |(addr & OTHER_BITS);

  always_comb begin
    if (stray)        ident = 8'h00;
    else if (addr[0]) ident = odd_par_byte(DEV_LOW7);
    else              ident = odd_par_byte(MFG_LOW7);
  end

endmodule

// File: rtl/erasable_byte_store.sv
module erasable_byte_store
  import erom_pkg::*;
#(
  parameter int         DEPTH    = 256,
  parameter logic [6:0] MFG_LOW7 = 7'h17,
  parameter logic [6:0] DEV_LOW7 = 7'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        vpp_hi,
  input  logic        id_hi,
  input  logic        erase,
  input  logic [15:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en
);

  localparam int AW = $clog2(DEPTH);

  erom_mode_e    mode;
  logic          drive;
  logic          ident_sel;
  logic          wr_fire;
  logic [AW-1:0] idx;
  logic [7:0]    cell_q;
  logic [7:0]    ident_b;

  assign idx = addr[AW-1:0];

  erom_mode_dec u_dec (
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .vpp_hi    (vpp_hi),
    .id_hi     (id_hi),
    .mode      (mode),
    .drive     (drive),
    .ident_sel (ident_sel)
  );

  erom_pulse_det u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .vpp_hi  (vpp_hi),
    .wr_fire (wr_fire)
  );

  erom_cell_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk   (clk),
    .rst_n (rst_n),
    .erase (erase),
    .wr_en (wr_fire),
    .widx  (idx),
    .wdata (din),
    .ridx  (idx),
    .rdata (cell_q)
  );

  erom_ident_rom #(.MFG_LOW7(MFG_LOW7), .DEV_LOW7(DEV_LOW7)) u_id (
    .addr  (addr),
    .ident (ident_b)
  );

  assign dout_en = drive;
  assign dout    = !drive ? 8'h00 : (ident_sel ? ident_b : cell_q);

  p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_en && dout == 8'h00));

  p_disable_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |-> !dout_en);

  p_vpp_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_hi |-> !dout_en);

  p_ident_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && id_hi && dout != 8'h00) |-> (^dout));

endmodule

// File: tb/erasable_byte_store_test.sv
`timescale 1ns/1ps
module erasable_byte_store_test;

  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic        clk = 1'b0;
  logic        rst_n, ce_n, oe_n, vpp_hi, id_hi, erase;
  logic [15:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  erasable_byte_store #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] exp_ident(input logic [15:0] a);
    if ((a & 16'hFDFE) != 16'h0000) return 8'h00;
    return a[0] ? 8'h85 : 8'h97;
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hi = 1'b0; erase = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hi = 1'b0; addr = a;
    #2;
    chk(dout_en && dout == model[a[AW-1:0]], req,
        {dout_en, dout}, {1'b1, model[a[AW-1:0]]});
  endtask

  task automatic rd_id(input logic [15:0] a, input string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hi = 1'b1; addr = a;
    #2;
    chk(dout_en && dout == exp_ident(a), req, {dout_en, dout}, {1'b1, exp_ident(a)});
    id_hi = 1'b0;
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d, input logic with_id);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b1; addr = a; din = d; id_hi = with_id;
    @(negedge clk);
    ce_n = 1'b0;
    #2;
    chk(!dout_en, "R5", {dout_en, dout}, 9'h000);
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b0; id_hi = 1'b0;
    model[a[AW-1:0]] &= d;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b0; id_hi = 1'b0;
    erase = 1'b0; addr = '0; din = '0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!dout_en, "R3", {dout_en, dout}, 9'h000);
    rst_n = 1'b1;

    // R1: erased after reset
    rd(16'h0000, "R1");
    rd(16'h00FF, "R1");
    rd(16'h0042, "R1");

    // R6: AND merge, neighbours untouched
    prog(16'h0005, 8'hA5, 1'b0);
    rd(16'h0005, "R6");
    prog(16'h0005, 8'h0F, 1'b0);
    rd(16'h0005, "R6");
    chk(model[5] == 8'h05, "R6", {1'b0, model[5]}, 9'h005);
    rd(16'h0004, "R6");
    rd(16'h0006, "R6");
    prog(16'h0005, 8'hFF, 1'b0);
    rd(16'h0005, "R6");

    // R2: upper address bits alias
    rd(16'h0105, "R2");
    rd(16'hFF05, "R2");

    // R7: only first low edge writes
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b1; addr = 16'h0009; din = 8'hF0;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); din = 8'h00;
    @(negedge clk); din = 8'h00;
    @(negedge clk); ce_n = 1'b1; vpp_hi = 1'b0;
    model[9] &= 8'hF0;
    rd(16'h0009, "R7");

    // R7: inhibit with ce_n high
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b1; oe_n = 1'b0; addr = 16'h000A; din = 8'h00;
    repeat (3) begin
      @(negedge clk);
      #2 chk(!dout_en && dout == 8'h00, "R3", {dout_en, dout}, 9'h000);
    end
    idle();
    rd(16'h000A, "R7");

    // R4: output disabled
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b0; addr = 16'h0005;
    #2 chk(!dout_en && dout == 8'h00, "R4", {dout_en, dout}, 9'h000);
    // R3: standby with identifier flag
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; id_hi = 1'b1; addr = 16'h0000;
    #2 chk(!dout_en, "R3", {dout_en, dout}, 9'h000);
    idle();

    // R9: identifier readout
    rd_id(16'h0000, "R9");
    rd_id(16'h0001, "R9");
    rd_id(16'h0201, "R9");
    rd_id(16'h0004, "R9");
    rd_id(16'h8001, "R9");
    chk(^(8'h97) && ^(8'h85), "R9", 9'h000, 9'h000);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; id_hi = 1'b1; addr = 16'h0000;
    #2 chk(!dout_en, "R4", {dout_en, dout}, 9'h000);
    idle();

    // R5: identifier flag during a program pulse is irrelevant
    prog(16'h0030, 8'h5A, 1'b1);
    rd(16'h0030, "R5");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      logic [15:0] a;
      op = $urandom % 4;
      a  = 16'($urandom);
      case (op)
        0: prog(a, 8'($urandom), 1'b0);
        1, 2: rd(a, "R2");
        default: rd_id((a[1:0] == 2'b00) ? 16'(a[2]) : a, "R9");
      endcase
    end

    // R8: erase and program edge in the same cycle
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b1; addr = 16'h0014; din = 8'h00;
    @(negedge clk);
    ce_n = 1'b0; erase = 1'b1;
    @(negedge clk);
    erase = 1'b0; ce_n = 1'b1; vpp_hi = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    rd(16'h0014, "R8");
    rd(16'h0005, "R8");
    rd(16'h0009, "R8");
    rd(16'h0030, "R8");
    prog(16'h0014, 8'h3C, 1'b0);
    rd(16'h0014, "R8");

    idle();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule